// File: doc/BRIEF.md
# Register-Mapped Doubler with Memory Writeback

This peripheral sits on a simple memory-mapped register bus and exposes four register windows, picked by a two-bit region-select input. Each window spans 64 bytes of offset. A byte written to the I/O window is doubled and kept for read-back. A byte written to the compute window is doubled and written out to host memory. That write is one 64-bit transfer on a valid/ready memory-master port, aimed at a base address that software loads as two 32-bit halves. A single level-sensitive interrupt line reports completion. Software reads and clears it through the interrupt window.

Bus accesses take effect in one cycle. A write is registered at the clock edge where `bus_valid` and `bus_write` are high. Read data is combinational while `bus_valid` is high and `bus_write` is low. The access size is given in bytes on `bus_size`.

Region encoding: 0 is the I/O window, 1 is the compute window, 2 is the interrupt window, and 3 is the base-address window.

Top module: `dbl_dma_periph`

## Requirements
- R1: After reset, `irq_o` is 0, `dma_valid` is 0, the stored I/O value is 0 and the base address is 0.
- R2: A 1-byte write to region 0 stores twice the byte as a 9-bit value, and sets the interrupt flag on the following edge. A 1-byte read of region 0 returns that stored value, zero-extended to 32 bits.
- R3: In regions 0, 1 and 2, an access whose size is not 1 byte is ignored when it is a write, and returns 32'hFFFF_FFFF when it is a read.
- R4: A 1-byte write to region 1 while no transfer is pending raises `dma_valid` on the next cycle. The transfer carries `dma_data` equal to twice the byte, zero-extended to 64 bits, and `dma_addr` equal to the base address at the time of the write.
- R5: While `dma_valid` is high and `dma_ready` is low, `dma_valid`, `dma_addr` and `dma_data` hold their values. The interrupt flag is set only on the edge where `dma_valid` and `dma_ready` are both high, and `dma_valid` falls on that same edge.
- R6: A region-1 write that arrives while `dma_valid` is high is dropped, and the pending transfer is unchanged.
- R7: A 1-byte read of region 2 returns the flag in bit 0. A 1-byte write of a nonzero byte sets the flag, and a write of zero clears it. Set events win over a clear in the same cycle, and `irq_o` always equals the flag.
- R8: In region 3, only 4-byte writes have effect. Offset 0 replaces bits 31:0 of the base and keeps bits 63:32. Offset 4 replaces bits 63:32 and keeps bits 31:0. Other offsets and sizes are ignored.
- R9: Reads of region 1 and region 3 always return 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_region | input | 2 | Register window select |
| bus_offset | input | 6 | Byte offset within the window |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Level interrupt |
| dma_valid | output | 1 | Memory write request |
| dma_ready | input | 1 | Memory write accepted |
| dma_addr | output | 64 | Host write address |
| dma_data | output | 64 | Little-endian write data |

## Verification
The hardest situation to reach is a second compute write that lands while a transfer is still waiting for acceptance. The stimulus holds `dma_ready` low after the first compute write and issues another compute write with a different operand. It then checks that the pending address and data are unchanged and that the interrupt stays low until `dma_ready` is finally raised. The same stalled transfer is also used to confirm that the interrupt rises on the accept edge and not before it.

// File: rtl/dbl_dma_periph.sv
module dbl_dma_periph #(
  parameter int BUS_W  = 32,
  parameter int OFF_W  = 6,
  parameter int OP_W   = 8,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_region,
  input  logic [OFF_W-1:0]  bus_offset,
  input  logic [3:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_data
);
  localparam int RES_W = OP_W + 1;
  localparam int HALF  = ADDR_W / 2;
  localparam logic [1:0] RG_IO = 2'd0, RG_CMP = 2'd1, RG_IRQ = 2'd2, RG_BASE = 2'd3;

  logic [RES_W-1:0]  io_q;
  logic [ADDR_W-1:0] base_q;
  logic              flag_q;

  wire wr      = bus_valid & bus_write;
  wire rd      = bus_valid & ~bus_write;
  wire byte_ok = bus_size == 4'd1;
  wire word_ok = bus_size == 4'd4;
  wire [RES_W-1:0] dbl = {bus_wdata[OP_W-1:0], 1'b0};

  wire io_wr   = wr & byte_ok & (bus_region == RG_IO);
  wire cmp_wr  = wr & byte_ok & (bus_region == RG_CMP) & ~dma_valid;
  wire irq_wr  = wr & byte_ok & (bus_region == RG_IRQ);
  wire lo_wr   = wr & word_ok & (bus_region == RG_BASE) & (bus_offset == OFF_W'(0));
  wire hi_wr   = wr & word_ok & (bus_region == RG_BASE) & (bus_offset == OFF_W'(4));
  wire done    = dma_valid & dma_ready;
  wire set_irq = io_wr | done | (irq_wr & |bus_wdata[OP_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_q      <= '0;
      base_q    <= '0;
      flag_q    <= 1'b0;
      dma_valid <= 1'b0;
      dma_addr  <= '0;
      dma_data  <= '0;
    end else begin
      if (io_wr) io_q <= dbl;
      if (lo_wr) base_q[HALF-1:0] <= bus_wdata[HALF-1:0];
      if (hi_wr) base_q[ADDR_W-1:HALF] <= bus_wdata[HALF-1:0];
      if (set_irq) flag_q <= 1'b1;
      else if (irq_wr) flag_q <= 1'b0;
      if (cmp_wr) begin
        dma_valid <= 1'b1;
        dma_addr  <= base_q;
        dma_data  <= DATA_W'(dbl);
      end else if (done) begin
        dma_valid <= 1'b0;
      end
    end
  end

  assign irq_o = flag_q;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_region)
        RG_IO:   bus_rdata = byte_ok ? BUS_W'(io_q) : '1;
        RG_IRQ:  bus_rdata = byte_ok ? BUS_W'(flag_q) : '1;
        default: bus_rdata = '1;
      endcase
    end
  end
endmodule

module dbl_dma_periph_chk #(
  parameter int BUS_W  = 32,
  parameter int OFF_W  = 6,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [1:0]        bus_region,
  input logic [3:0]        bus_size,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              irq_o,
  input logic              dma_valid,
  input logic              dma_ready,
  input logic [ADDR_W-1:0] dma_addr,
  input logic [DATA_W-1:0] dma_data
);
  wire cmp_req = bus_valid & bus_write & (bus_region == 2'd1) & (bus_size == 4'd1);
  wire irq_clr = bus_valid & bus_write & (bus_region == 2'd2) & (bus_size == 4'd1)
                 & (bus_wdata[7:0] == 8'd0);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_data));
  a_r5_irq_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && dma_ready && !cmp_req |=> irq_o && !dma_valid);
  a_r4_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req && !dma_valid |=> dma_valid);
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req && dma_valid && !dma_ready |=> $stable(dma_data));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !(dma_valid && dma_ready) |=> !irq_o);
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> !irq_o && !dma_valid);
endmodule

bind dbl_dma_periph dbl_dma_periph_chk #(
  .BUS_W(BUS_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_region(bus_region), .bus_size(bus_size), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .dma_valid(dma_valid), .dma_ready(dma_ready),
  .dma_addr(dma_addr), .dma_data(dma_data)
);

// File: tb/dbl_dma_periph_tb.sv
module dbl_dma_periph_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_region = '0;
  logic [5:0]  bus_offset = '0;
  logic [3:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, dma_valid;
  logic        dma_ready = 1'b0;
  logic [63:0] dma_addr, dma_data;
  int errors = 0, checks = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_dma_periph u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_region(bus_region), .bus_offset(bus_offset), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
    .dma_data(dma_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] rg, input logic [5:0] off, input logic [3:0] sz, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_region = rg; bus_offset = off; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [1:0] rg, input logic [3:0] sz, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_region = rg; bus_offset = 0; bus_size = sz;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic t_reset;
    chk(irq_o == 0, "R1 irq", 64'(irq_o), 0);
    chk(dma_valid == 0, "R1 dma_valid", 64'(dma_valid), 0);
  endtask

  task automatic t_io;
    logic [31:0] d;
    rd(0, 1, d); chk(d == 0, "R1 io reset value", 64'(d), 0);
    wr(0, 0, 1, 32'h21);
    chk(irq_o == 1, "R2 irq after io write", 64'(irq_o), 1);
    rd(0, 1, d); chk(d == 32'h42, "R2 io read", 64'(d), 64'h42);
    wr(0, 0, 1, 32'hFF);
    rd(0, 1, d); chk(d == 32'h1FE, "R2 io read max", 64'(d), 64'h1FE);
    wr(2, 0, 1, 0);
    chk(irq_o == 0, "R7 clear", 64'(irq_o), 0);
  endtask

  task automatic t_size;
    logic [31:0] d;
    wr(0, 0, 2, 32'h05);
    chk(irq_o == 0, "R3 sized io write no irq", 64'(irq_o), 0);
    rd(0, 1, d); chk(d == 32'h1FE, "R3 sized io write ignored", 64'(d), 64'h1FE);
    rd(0, 2, d); chk(d == 32'hFFFFFFFF, "R3 io wide read", 64'(d), 64'hFFFFFFFF);
    wr(2, 0, 4, 32'h1);
    chk(irq_o == 0, "R3 sized irq write ignored", 64'(irq_o), 0);
    rd(2, 4, d); chk(d == 32'hFFFFFFFF, "R3 irq wide read", 64'(d), 64'hFFFFFFFF);
    wr(1, 0, 2, 32'h3);
    chk(dma_valid == 0, "R3 sized compute write ignored", 64'(dma_valid), 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(2, 0, 1, 32'h3);
    chk(irq_o == 1, "R7 set nonzero", 64'(irq_o), 1);
    rd(2, 1, d); chk(d == 1, "R7 read set", 64'(d), 1);
    wr(2, 0, 1, 0);
    rd(2, 1, d); chk(d == 0, "R7 read clear", 64'(d), 0);
  endtask

  task automatic t_dma_stall;
    logic [31:0] d;
    wr(3, 0, 4, 32'h11223344);
    wr(3, 4, 4, 32'h55667788);
    wr(3, 0, 1, 32'hDEADBEEF);
    wr(3, 8, 4, 32'hDEADBEEF);
    rd(3, 4, d); chk(d == 32'hFFFFFFFF, "R9 base read", 64'(d), 64'hFFFFFFFF);
    dma_ready = 0;
    wr(1, 0, 1, 32'h80);
    chk(dma_valid == 1, "R4 valid raised", 64'(dma_valid), 1);
    chk(dma_addr == 64'h5566778811223344, "R8 R4 address", dma_addr, 64'h5566778811223344);
    chk(dma_data == 64'h100, "R4 data", dma_data, 64'h100);
    chk(irq_o == 0, "R5 no irq before accept", 64'(irq_o), 0);
    wr(1, 0, 1, 32'h05);
    chk(dma_data == 64'h100, "R6 drop data", dma_data, 64'h100);
    chk(dma_valid == 1, "R5 valid held", 64'(dma_valid), 1);
    @(negedge clk);
    chk(irq_o == 0, "R5 no irq while stalled", 64'(irq_o), 0);
    rd(1, 1, d); chk(d == 32'hFFFFFFFF, "R9 compute read", 64'(d), 64'hFFFFFFFF);
    dma_ready = 1;
    @(negedge clk);
    chk(dma_valid == 0, "R5 valid drops on accept", 64'(dma_valid), 0);
    chk(irq_o == 1, "R5 irq on accept", 64'(irq_o), 1);
    wr(2, 0, 1, 0);
  endtask

  task automatic t_dma_ready;
    wr(3, 4, 4, 32'hAABBCCDD);
    dma_ready = 1;
    bus_valid = 1; bus_write = 1; bus_region = 1; bus_offset = 0; bus_size = 1; bus_wdata = 32'h7F;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    chk(dma_addr == 64'hAABBCCDD11223344, "R8 high half replaced", dma_addr, 64'hAABBCCDD11223344);
    chk(dma_data == 64'hFE, "R4 data second", dma_data, 64'hFE);
    chk(irq_o == 0, "R5 irq not before accept", 64'(irq_o), 0);
    @(negedge clk);
    chk(irq_o == 1, "R5 irq after accept", 64'(irq_o), 1);
    chk(dma_valid == 0, "R5 valid cleared", 64'(dma_valid), 0);
    dma_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_io();
    t_size();
    t_irq();
    t_dma_stall();
    t_dma_ready();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule